// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This block collects thirteen event pulses from a UART core, latches each one in a sticky status bit and raises a single interrupt line while any latched event is also unmasked. Software never writes the mask directly. One register address unmasks sources, another masks them, and a third returns the current mask. A driver can therefore save the mask, mask every source for a critical section, and later restore the saved value by writing it to the unmask address.

The register bus is minimal: a word address, a write strobe, write data and combinational read data. Writes take effect on the rising clock edge on which the write strobe is high. The event generators belong to the UART core and are not part of this block.

Top module: `irq_mask_unit`

## Requirements
- R1: After the synchronous active-high reset, the mask is all zeros (every source masked), the status is all zeros and the interrupt output is low.
- R2: A write to address 0 (unmask) sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to address 1 (mask) clears every mask bit whose write-data bit is 1 and leaves the others unchanged. Writing 0x1FFF there masks all thirteen sources.
- R4: Address 2 reads the current mask (bit i means source i is unmasked). Writes to address 2 are ignored. Addresses 0 and 1 read as zero. A mask value read back and then written to address 0 after a full mask restores the same mask.
- R5: Address 3 reads the status. Status bit i is set one clock after a pulse on event input bit i. The bit positions are: bit 0 RX FIFO trigger level, bit 1 RX FIFO empty, bit 2 RX FIFO full, bit 3 TX FIFO empty, bit 4 TX FIFO full, and bits 5 to 12 the remaining UART sources.
- R6: A write to address 3 clears every status bit whose write-data bit is 1. Bits written 0 keep their value. An event that arrives on the same edge as the clear of its bit leaves that bit set.
- R7: The interrupt output is registered. It is high in the cycle after a cycle in which some status bit and its mask bit are both 1, and low in the cycle after a cycle in which no such bit exists.
- R8: An event on a masked source still sets its status bit but does not raise the interrupt. Masking a pending source drops the interrupt.
- R9: Write-data bits 31 to 13 have no effect, and reads of the mask and status return zeros in bits 31 to 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register word address |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| eventIn | input | 13 | Single-cycle event pulses from the UART core |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a status clear that coincides with a new event on the same bit, because the clear and the event come from independent inputs and must land on the same clock edge. The bench drives both from one task, raising the write strobe on address 3 and the event bit at the same falling edge, then reads the status back. The one-cycle lag of the registered interrupt after a clear or a re-mask is checked by sampling the output on two consecutive cycles.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

  // Register word addresses. Software depends on these.
  localparam int unsigned ADDR_UNMASK = 0;
  localparam int unsigned ADDR_MASK   = 1;
  localparam int unsigned ADDR_VIEW   = 2;
  localparam int unsigned ADDR_STATUS = 3;

  // Source bit positions; the UART core drives eventIn in this order.
  localparam int unsigned SRC_RX_TRIG  = 0;
  localparam int unsigned SRC_RX_EMPTY = 1;
  localparam int unsigned SRC_RX_FULL  = 2;
  localparam int unsigned SRC_TX_EMPTY = 3;
  localparam int unsigned SRC_TX_FULL  = 4;

  // Strobes from control to datapath, one per state update.
  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic clrStatus;
  } regStrobes_t;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2
  } readSel_t;

endpackage

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output regStrobes_t       strobes,
  output readSel_t          readSel
);

  logic hitUnmask;
  logic hitMask;
  logic hitView;
  logic hitStatus;

  always_comb begin
    hitUnmask = (addr == ADDR_W'(ADDR_UNMASK));
    hitMask   = (addr == ADDR_W'(ADDR_MASK));
    hitView   = (addr == ADDR_W'(ADDR_VIEW));
    hitStatus = (addr == ADDR_W'(ADDR_STATUS));
  end

  // Writes to the view address produce no strobe: the mask is read-only there.
  always_comb begin
    strobes.setMask   = wrEn & hitUnmask;
    strobes.clrMask   = wrEn & hitMask;
    strobes.clrStatus = wrEn & hitStatus;
  end

  always_comb begin
    if (hitView)        readSel = RD_MASK;
    else if (hitStatus) readSel = RD_STATUS;
    else                readSel = RD_ZERO;
  end

endmodule

// File: rtl/irq_mask_datapath.sv
module irq_mask_datapath
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  regStrobes_t        strobes,
  input  readSel_t           readSel,
  input  logic [NUM_SRC-1:0] srcBits,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] statusQ,
  output logic               irqOut
);

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] setBits;
  logic [NUM_SRC-1:0] clrBits;
  logic [NUM_SRC-1:0] maskNext;

  always_comb begin
    setBits  = strobes.setMask ? srcBits : '0;
    clrBits  = strobes.clrMask ? srcBits : '0;
    // Clearing is applied last so it dominates any set of the same bit.
    maskNext = (maskQ | setBits) & ~clrBits;
  end

  always_ff @(posedge clk) begin
    if (rst) maskQ <= '0;
    else     maskQ <= maskNext;
  end

  // One sticky cell per source; a fresh event outranks its own clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : gStatus
    logic clrHit;
    assign clrHit = strobes.clrStatus & srcBits[i];
    always_ff @(posedge clk) begin
      if (rst) statusQ[i] <= 1'b0;
      else     statusQ[i] <= eventIn[i] | (statusQ[i] & ~clrHit);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irqOut <= 1'b0;
    else     irqOut <= |(statusQ & maskQ);
  end

  always_comb begin
    case (readSel)
      RD_MASK:   rdData = {{PAD_W{1'b0}}, maskQ};
      RD_STATUS: rdData = {{PAD_W{1'b0}}, statusQ};
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic               irqOut
);

  regStrobes_t        strobes;
  readSel_t           readSel;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] srcBits;
  logic               unusedHigh;

  assign srcBits    = wrData[NUM_SRC-1:0];
  assign unusedHigh = ^wrData[DATA_W-1:NUM_SRC];

  irq_mask_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .strobes(strobes),
    .readSel(readSel)
  );

  irq_mask_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) uPath (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .readSel(readSel),
    .srcBits(srcBits),
    .eventIn(eventIn),
    .rdData (rdData),
    .maskQ  (maskQ),
    .statusQ(statusQ),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk
  import irq_mask_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  addr,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [NUM_SRC-1:0] eventIn,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] statusQ,
  input logic               irqOut
);

  logic [NUM_SRC-1:0] wBits;
  logic               wUnmask;
  logic               wMask;
  logic               wStatus;

  assign wBits   = wrData[NUM_SRC-1:0];
  assign wUnmask = wrEn && (addr == ADDR_W'(ADDR_UNMASK));
  assign wMask   = wrEn && (addr == ADDR_W'(ADDR_MASK));
  assign wStatus = wrEn && (addr == ADDR_W'(ADDR_STATUS));

  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> (maskQ == '0 && statusQ == '0 && !irqOut));

  a_r2_unmask_sets: assert property (@(posedge clk) disable iff (rst)
    wUnmask |=> ((maskQ & $past(wBits)) == $past(wBits)));

  a_r3_mask_clears: assert property (@(posedge clk) disable iff (rst)
    wMask |=> ((maskQ & $past(wBits)) == '0));

  a_r4_mask_only_via_strobes: assert property (@(posedge clk) disable iff (rst)
    !(wUnmask || wMask) |=> $stable(maskQ));

  a_r5_event_latches: assert property (@(posedge clk) disable iff (rst)
    (eventIn != '0) |=> ((statusQ & $past(eventIn)) == $past(eventIn)));

  a_r6_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !wStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  a_r7_irq_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irqOut == $past(|(statusQ & maskQ))));

endmodule

bind irq_mask_unit irq_mask_unit_chk #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk (
  .clk    (clk),
  .rst    (rst),
  .addr   (addr),
  .wrEn   (wrEn),
  .wrData (wrData),
  .eventIn(eventIn),
  .maskQ  (maskQ),
  .statusQ(statusQ),
  .irqOut (irqOut)
);

// File: tb/irq_mask_unit_test.sv
`timescale 1ns/1ps
module irq_mask_unit_test;

  localparam int unsigned NUM_SRC = 13;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 3;
  localparam logic [ADDR_W-1:0] A_UNMASK = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_VIEW   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [ADDR_W-1:0]  addr = '0;
  logic               wrEn = 1'b0;
  logic [DATA_W-1:0]  wrData = '0;
  logic [DATA_W-1:0]  rdData;
  logic [NUM_SRC-1:0] eventIn = '0;
  logic               irqOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_mask_unit #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .eventIn(eventIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic pulse(input logic [NUM_SRC-1:0] ev);
    @(negedge clk);
    eventIn = ev;
    @(negedge clk);
    eventIn = '0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(A_VIEW, v);   check("R1 mask after reset", v, 32'h0);
    regRead(A_STATUS, v); check("R1 status after reset", v, 32'h0);
    check("R1 irq after reset", {31'd0, irqOut}, 32'h0);
  endtask

  task automatic testUnmaskMask();
    logic [31:0] v;
    regWrite(A_UNMASK, 32'h0005);
    regRead(A_VIEW, v); check("R2 unmask 0x5", v, 32'h0005);
    regWrite(A_UNMASK, 32'h0008);
    regRead(A_VIEW, v); check("R2 zeros keep bits", v, 32'h000D);
    regRead(A_UNMASK, v); check("R4 unmask addr reads zero", v, 32'h0);
    regRead(A_MASK, v);   check("R4 mask addr reads zero", v, 32'h0);
    regWrite(A_MASK, 32'h0004);
    regRead(A_VIEW, v); check("R3 mask one bit", v, 32'h0009);
    regWrite(A_MASK, 32'h1FFF);
    regRead(A_VIEW, v); check("R3 mask all", v, 32'h0);
  endtask

  task automatic testSaveRestore();
    logic [31:0] v;
    logic [31:0] saved;
    regWrite(A_UNMASK, 32'h0A0A);
    regWrite(A_VIEW, 32'h1FFF);
    regRead(A_VIEW, v); check("R4 view write ignored", v, 32'h0A0A);
    saved = v;
    regWrite(A_MASK, 32'h1FFF);
    regRead(A_VIEW, v); check("R4 fully masked", v, 32'h0);
    regWrite(A_UNMASK, saved);
    regRead(A_VIEW, v); check("R4 restore", v, 32'h0A0A);
    regWrite(A_MASK, 32'h1FFF);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    // rx empty (bit 1) and tx full (bit 4), both masked
    pulse(13'h0012);
    regRead(A_STATUS, v); check("R5 status latches bits 1 and 4", v, 32'h0012);
    @(negedge clk);
    check("R8 masked events give no irq", {31'd0, irqOut}, 32'h0);
    regWrite(A_STATUS, 32'h0002);
    regRead(A_STATUS, v); check("R6 clear bit 1 only", v, 32'h0010);
    // clear of bit 4 on the same edge as a new bit 4 event
    @(negedge clk);
    addr = A_STATUS; wrData = 32'h0010; wrEn = 1'b1; eventIn = 13'h0010;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; eventIn = '0;
    regRead(A_STATUS, v); check("R6 event beats same-edge clear", v, 32'h0010);
    regWrite(A_STATUS, 32'h1FFF);
    regRead(A_STATUS, v); check("R6 clear all", v, 32'h0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    regWrite(A_UNMASK, 32'h0008);
    pulse(13'h0008);
    check("R7 irq low one cycle after latch", {31'd0, irqOut}, 32'h0);
    @(negedge clk);
    check("R7 irq high", {31'd0, irqOut}, 32'h1);
    regWrite(A_STATUS, 32'h0008);
    check("R7 irq lag after clear", {31'd0, irqOut}, 32'h1);
    @(negedge clk);
    check("R7 irq low after clear", {31'd0, irqOut}, 32'h0);
    pulse(13'h0008);
    @(negedge clk);
    check("R8 irq before remask", {31'd0, irqOut}, 32'h1);
    regWrite(A_MASK, 32'h0008);
    @(negedge clk);
    check("R8 remask drops irq", {31'd0, irqOut}, 32'h0);
    regRead(A_STATUS, v); check("R8 status kept when masked", v, 32'h0008);
    regWrite(A_STATUS, 32'h1FFF);
  endtask

  task automatic testWide();
    logic [31:0] v;
    regWrite(A_UNMASK, 32'hFFFF_FFFF);
    regRead(A_VIEW, v); check("R9 mask upper bits zero", v, 32'h1FFF);
    regWrite(A_MASK, 32'hFFFF_E000);
    regRead(A_VIEW, v); check("R9 upper mask bits no effect", v, 32'h1FFF);
    pulse(13'h1FFF);
    regWrite(A_STATUS, 32'hFFFF_E000);
    regRead(A_STATUS, v); check("R9 upper clear bits no effect", v, 32'h1FFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testUnmaskMask();
    testSaveRestore();
    testStatus();
    testIrq();
    testWide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule